// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This block is an up-counter for timing and event counting. In timer mode it advances on a tick that is the system clock divided by a power of two from 2 to 256. In event mode it advances on chosen transitions of an external signal. That signal is first brought into the system clock domain through a two-stage synchronizer, and its edges are then detected in that domain. The counter value can be read but never written. When the counter wraps it raises a one-cycle interrupt pulse. It can also be told to stop after a wrap and stay stopped until software restarts it.

There are two controls for starting and clearing. A run input starts and stops counting. An enable input clears the counter, the prescaler and the synchronizer at once, without waiting for a clock edge, and holds them cleared while it is low. The source select, edge mode and divider select are loaded into an internal configuration register only on clock edges where run is low. Changes made while run is high have no effect until the next stop. The prescaler restarts from zero whenever counting resumes, so the first increment comes one full divider period after run rises.

Top module: `evt_timer`

## Requirements
- R1: After the system reset is released, the count reads 0 and the interrupt output is low. The default counter width is 16 bits.
- R2: While the enable input is low, the count is 0. Taking enable low clears the count at once, with no clock edge needed.
- R3: While run is low, the count holds its value.
- R4: In timer mode with divider select s (0 to 7), the count advances once every P = 2^(s+1) clock edges. After run rises, the count reads floor(k/P) following the k-th rising edge.
- R5: The edge mode encoding is 2'b00 = no edges counted, 2'b01 = low-to-high, 2'b10 = high-to-low, 2'b11 = both. In event mode only the selected transitions of the external input advance the count.
- R6: A transition of the external input placed before a rising edge shows up in the count after the third rising edge. After the second edge the count is still unchanged.
- R7: An increment from the all-ones value wraps the count to 0. On that same edge the interrupt output goes high, for exactly one cycle.
- R8: With stop-on-wrap set, the count stays at 0 after a wrap, even while run stays high. Counting resumes only after run is taken low for at least one clock edge and raised again.
- R9: Changes to the divider select or the source select made while run is high are ignored. They take effect after run has been low for a clock edge.
- R10: With stop-on-wrap clear, counting continues through a wrap: 0, then 1, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| en_i | input | 1 | Block enable; low clears the count and the prescaler and synchronizer asynchronously |
| run_i | input | 1 | Counting runs while high |
| div_sel_i | input | 3 | Timer divider select; period is 2^(value+1) clocks |
| src_ext_i | input | 1 | 1 = count external edges, 0 = count prescaler ticks |
| edge_sel_i | input | 2 | External edge mode (00 none, 01 rising, 10 falling, 11 both) |
| stop_ovf_i | input | 1 | Stop counting after a wrap |
| ext_i | input | 1 | Asynchronous external event input |
| count_o | output | CNT_W | Current count, read-only |
| ovf_irq_o | output | 1 | One-cycle wrap interrupt pulse |

## Verification
The hardest situation to reach is the wrap. At the default 16-bit width and the fastest divider it takes 131,072 clock cycles, and the stop-on-wrap case needs a second wrap on top of that. The bench therefore builds the block with an 8-bit counter. This brings both the plain wrap and the stopped wrap within about 500 cycles, so every cycle around them can be checked. The bench also sweeps all eight divider settings and all four edge modes. In event mode it checks the synchronizer latency on every transition, one cycle before and at the cycle of the expected change.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [2:0]  div_sel;
    logic        src_ext;
    edge_mode_e  edge_mode;
  } evt_cfg_t;

  // Edge qualification: cur/prev are consecutive synchronized samples.
  function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // Number of low prescaler bits that must be all ones for a tick.
  function automatic int unsigned tick_bits(logic [2:0] sel);
    tick_bits = int'(sel) + 1;
  endfunction

endpackage

// File: rtl/evt_prescaler.sv
`timescale 1ns/1ps
module evt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_w;

  always_comb begin
    for (int b = 0; b < PRE_W; b++) begin
      mask_w[b] = (b < int'(evt_pkg::tick_bits(3'(sel_i))));
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      pre_q <= '0;
    end else if (!active_i) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick_o = active_i && ((pre_q & mask_w) == mask_w);
endmodule

// File: rtl/evt_edge_det.sv
`timescale 1ns/1ps
module evt_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 clr_n,
  input  logic                 ext_i,
  input  evt_pkg::edge_mode_e  mode_i,
  output logic                 hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hit_o = evt_pkg::edge_hit(mode_i, sync_q[SYNC_STAGES-1], prev_q);
endmodule

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             run_i,
  input  logic             stop_ovf_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             halted_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             halt_q;
  logic             at_max_w;

  assign at_max_w = (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (!run_i) begin
        halt_q <= 1'b0;
      end
      if (inc_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (at_max_w) begin
          ovf_q <= 1'b1;
          if (stop_ovf_i) begin
            halt_q <= 1'b1;
          end
        end
      end
    end
  end

  assign count_o  = cnt_q;
  assign ovf_o    = ovf_q;
  assign halted_o = halt_q;
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer #(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             src_ext_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             stop_ovf_i,
  input  logic             ext_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_irq_o
);
  import evt_pkg::*;

  logic         clr_n;
  evt_cfg_t     cfg_q;
  logic         halted_w;
  logic         active_w;
  logic         tick_w;
  logic         hit_w;
  logic         inc_w;

  assign clr_n = rst_n & en_i;

  // Configuration is only taken while the counter is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{div_sel: '0, src_ext: 1'b0, edge_mode: EDGE_NONE};
    end else if (!run_i) begin
      cfg_q.div_sel   <= 3'(div_sel_i);
      cfg_q.src_ext   <= src_ext_i;
      cfg_q.edge_mode <= edge_mode_e'(edge_sel_i);
    end
  end

  assign active_w = run_i & ~halted_w;

  evt_prescaler #(.SEL_W(SEL_W)) pre_i (
    .clk      (clk),
    .clr_n    (clr_n),
    .active_i (active_w),
    .sel_i    (SEL_W'(cfg_q.div_sel)),
    .tick_o   (tick_w)
  );

  evt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .ext_i  (ext_i),
    .mode_i (cfg_q.edge_mode),
    .hit_o  (hit_w)
  );

  assign inc_w = active_w & (cfg_q.src_ext ? hit_w : tick_w);

  evt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .clr_n      (clr_n),
    .run_i      (run_i),
    .stop_ovf_i (stop_ovf_i),
    .inc_i      (inc_w),
    .count_o    (count_o),
    .ovf_o      (ovf_irq_o),
    .halted_o   (halted_w)
  );
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             en_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_irq_o,
  input logic             inc_w,
  input logic             halted_w
);
  p_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (count_o == '0 && !ovf_irq_o));

  p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !inc_w |=> $stable(count_o));

  p_step_r4: assert property (@(posedge clk) disable iff (!clr_n)
    inc_w |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!clr_n)
    ovf_irq_o |=> !ovf_irq_o);

  p_irq_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    ovf_irq_o |-> (count_o == '0));

  p_halt_zero_r8: assert property (@(posedge clk) disable iff (!clr_n)
    halted_w |-> (count_o == '0 && !inc_w));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_n     (clr_n),
  .en_i      (en_i),
  .count_o   (count_o),
  .ovf_irq_o (ovf_irq_o),
  .inc_w     (inc_w),
  .halted_w  (halted_w)
);

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         run = 1'b0;
  logic [2:0]   div_sel = 3'd0;
  logic         src_ext = 1'b0;
  logic [1:0]   edge_sel = 2'b00;
  logic         stop_ovf = 1'b0;
  logic         ext = 1'b0;
  logic [W-1:0] count;
  logic         irq;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  evt_timer #(.CNT_W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .run_i      (run),
    .div_sel_i  (div_sel),
    .src_ext_i  (src_ext),
    .edge_sel_i (edge_sel),
    .stop_ovf_i (stop_ovf),
    .ext_i      (ext),
    .count_o    (count),
    .ovf_irq_o  (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: asynchronous clear by the enable input, checked between edges.
  task automatic clear_cnt();
    @(negedge clk);
    en = 1'b0;
    #2;
    chk("R2 async clear", int'(count), 0);
    @(negedge clk);
    en = 1'b1;
  endtask

  // R5/R6: drive one transition and check latency and counting.
  task automatic toggle_chk(input logic v, input logic counts, inout int exp_cnt);
    ext = v;
    wait_neg(2);
    chk("R6 not yet counted", int'(count), exp_cnt);
    wait_neg(1);
    if (counts) exp_cnt++;
    chk("R5 R6 edge counted", int'(count), exp_cnt);
    wait_neg(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(1);
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset irq", int'(irq), 0);
    en = 1'b1;
    wait_neg(2);

    // R4 sweep of all divider settings, then R3 hold.
    for (int s = 0; s < 8; s++) begin
      int p;
      p = 2 << s;
      run = 1'b0;
      div_sel = 3'(s);
      src_ext = 1'b0;
      clear_cnt();
      wait_neg(2);
      run = 1'b1;
      for (int k = 1; k <= 3 * p + 1; k++) begin
        wait_neg(1);
        chk("R4 prescaled count", int'(count), k / p);
      end
      run = 1'b0;
      wait_neg(5);
      chk("R3 hold while stopped", int'(count), 3);
    end

    // R9: divider and source changes while running are ignored.
    div_sel = 3'd2;
    clear_cnt();
    wait_neg(2);
    run = 1'b1;
    wait_neg(1);
    div_sel = 3'd0;
    src_ext = 1'b1;
    wait_neg(15);
    chk("R9 change ignored while running", int'(count), 2);
    run = 1'b0;
    src_ext = 1'b0;
    clear_cnt();
    wait_neg(2);
    run = 1'b1;
    wait_neg(16);
    chk("R9 change applied after stop", int'(count), 8);
    run = 1'b0;

    // R5 and R6 over all four edge modes.
    for (int m = 0; m < 4; m++) begin
      int exp_cnt;
      exp_cnt = 0;
      run = 1'b0;
      src_ext = 1'b1;
      edge_sel = 2'(m);
      ext = 1'b0;
      wait_neg(4);
      clear_cnt();
      wait_neg(2);
      run = 1'b1;
      wait_neg(1);
      for (int t = 0; t < 4; t++) begin
        toggle_chk(1'b1, m[0], exp_cnt);
        toggle_chk(1'b0, m[1], exp_cnt);
      end
      chk("R5 total per mode", int'(count), (m == 3) ? 8 : ((m == 0) ? 0 : 4));
      run = 1'b0;
    end

    // R7 and R10: wrap with stop-on-wrap clear.
    src_ext = 1'b0;
    div_sel = 3'd0;
    stop_ovf = 1'b0;
    clear_cnt();
    wait_neg(2);
    run = 1'b1;
    for (int k = 1; k <= 520; k++) begin
      wait_neg(1);
      chk("R7 R10 count through wrap", int'(count), (k / 2) % 256);
      chk("R7 irq pulse", int'(irq), (k == 512) ? 1 : 0);
    end
    run = 1'b0;

    // R8: stop after wrap, restart by toggling run.
    stop_ovf = 1'b1;
    clear_cnt();
    wait_neg(2);
    run = 1'b1;
    for (int k = 1; k <= 540; k++) begin
      wait_neg(1);
      chk("R8 halted after wrap", int'(count), (k < 512) ? k / 2 : 0);
      chk("R7 irq pulse with stop", int'(irq), (k == 512) ? 1 : 0);
    end
    run = 1'b0;
    wait_neg(1);
    run = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      wait_neg(1);
      chk("R8 resume after run toggle", int'(count), k / 2);
    end
    run = 1'b0;
    wait_neg(2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule